// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a byte-addressed requester and a slower line-oriented backing memory. Each set holds two lines. On a lookup, both lines of the indexed set are checked in the same cycle. A hit returns the addressed byte, or updates it for a write, in the cycle the request is presented. A miss stalls the requester and runs a miss sequence. If the chosen victim line is dirty, the sequence first writes it back. It then reads the missing line from memory and lets the held request complete as a hit.

The policies are write-back with write-allocate. An empty way is filled before any valid line is displaced. When both ways are valid, a single recency bit per set picks the way that was touched less recently. The default geometry is eight sets of four-byte lines behind a 13-bit byte address, which gives 64 bytes of data storage. Line size must be at least two bytes.

The miss sequence is a three-state machine:
- `CS_LOOKUP` (idle/compare) goes to `CS_WRBACK` on a miss whose victim is dirty.
- `CS_LOOKUP` goes to `CS_FILL` on a miss whose victim is clean or empty.
- `CS_WRBACK` goes to `CS_FILL` on the memory acknowledge.
- `CS_FILL` returns to `CS_LOOKUP` on the memory acknowledge, writing the returned line into the victim way.

Top module: `cache2w_top`

## Requirements
- R1: The byte address splits as tag = addr[12:5], set = addr[4:2], offset = addr[1:0] (default geometry). Addresses that differ only in the offset share a line. Addresses that differ in the set or tag bits use different lines.
- R2: Both ways of the indexed set are compared at once. A way hits only when it is valid and its stored tag equals the address tag, and at most one way hits.
- R3: On a read hit, `rsp_rdata` carries byte `offset` of the line, which is bits [8*offset+7 : 8*offset] of the memory line word.
- R4: A line that is not valid never hits, even when its stale tag matches the address tag.
- R5: On a miss, an invalid way of the indexed set is filled before any valid way is evicted. Way 0 is used when both ways are empty.
- R6: When both ways are valid, the way not most recently touched is evicted. Every hit and every fill marks the touched way as most recent.
- R7: A write hit changes only the cached byte and marks the line dirty. No hit causes any memory transaction.
- R8: An evicted line is written to memory, as a full line at line address {victim tag, set}, only if it is dirty. That write-back completes before the fill read for the same miss is issued.
- R9: A write miss loads the line from memory, then applies the write byte to it and marks it dirty.
- R10: `req_ready` is high in the same cycle as a hitting request. For a miss it is low from detection until the write-back (if any) and the fill are both acknowledged. The held request then completes as a hit in the next cycle.
- R11: A memory request (`mem_req_valid` with its address and write flag) is held stable until `mem_ack`. Exactly one fill read is issued per miss.
- R12: Reset clears every valid bit, dirty bit and recency bit, and leaves the memory port idle.
- R13: For three tags A, B, C in one set, the access sequence A, B, A, C, A, B gives miss, miss, hit, miss (evicting B), hit, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester presents an access; must be held until `req_ready` |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Access completes this cycle (hit) |
| rsp_rdata | output | 8 | Read byte, valid while `req_ready` is high on a read |
| mem_req_valid | output | 1 | Memory transaction pending |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line fill read |
| mem_req_addr | output | ADDR_W-OFF_W | Line address {tag, set} |
| mem_wdata | output | 8*LINE_BYTES | Write-back line data |
| mem_ack | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | 8*LINE_BYTES | Fill line data, valid with `mem_ack` |

## Verification
A hit gives `req_ready` and the read byte in the same cycle the request is driven. The bench therefore samples 1 ns after it drives the request at a falling edge. The bench memory acknowledges in the fourth cycle of each transaction. A miss therefore holds `req_ready` low for exactly 1 + n·4 sampled cycles, where n is 1 for a clean victim and 2 for a dirty one. The bench counts the stalled samples and compares them with that figure. Hit/miss, victim choice, write-back count, write-back address and ordering, and returned bytes are predicted by a reference model in the bench. That model holds tag, valid, dirty and recency state and a logical memory image, built only from the requirements.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic [1:0] {
        CS_LOOKUP = 2'd0,
        CS_WRBACK = 2'd1,
        CS_FILL   = 2'd2
    } cache_state_e;

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int unsigned SETS   = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [TAG_W-1:0]  cmp_tag_i,
    output logic              hit_o,
    output logic              valid_o,
    output logic              dirty_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LINE_W-1:0] line_o,
    input  logic              byte_we_i,
    input  logic [OFF_W-1:0]  byte_off_i,
    input  logic [7:0]        byte_i,
    input  logic              fill_we_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [LINE_W-1:0] fill_line_i
);

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // Status bits: cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we_i) begin
            valid_q[idx_i] <= 1'b1;
            dirty_q[idx_i] <= 1'b0;
        end else if (byte_we_i) begin
            dirty_q[idx_i] <= 1'b1;
        end
    end

    // Tag and data storage: no reset
    always_ff @(posedge clk) begin
        if (fill_we_i) begin
            tag_q[idx_i]  <= fill_tag_i;
            line_q[idx_i] <= fill_line_i;
        end else if (byte_we_i) begin
            line_q[idx_i][{byte_off_i, 3'b000} +: 8] <= byte_i;
        end
    end

    always_comb begin
        valid_o = valid_q[idx_i];
        dirty_o = dirty_q[idx_i];
        tag_o   = tag_q[idx_i];
        line_o  = line_q[idx_i];
        hit_o   = valid_q[idx_i] && (tag_q[idx_i] == cmp_tag_i);
    end

    // R7
    byte_write_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we_i |-> valid_q[idx_i]);

    // R9
    fill_then_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we_i |=> (valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]));

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int unsigned SETS  = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             touch_i,
    input  logic             touch_way_i,
    output logic             lru_way_o
);

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_i) begin
            lru_q[idx_i] <= ~touch_way_i;
        end
    end

    assign lru_way_o = lru_q[idx_i];

    // R6
    lru_points_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> (lru_q[$past(idx_i)] != $past(touch_way_i)));

endmodule

// File: rtl/cache2w_ctl.sv
module cache2w_ctl
    import cache2w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_i,
    input  logic victim_dirty_i,
    input  logic mem_ack_i,
    output logic in_lookup_o,
    output logic mem_req_valid_o,
    output logic mem_req_write_o,
    output logic fill_done_o
);

    cache_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_LOOKUP: if (miss_i)    state_d = victim_dirty_i ? CS_WRBACK : CS_FILL;
            CS_WRBACK: if (mem_ack_i) state_d = CS_FILL;
            CS_FILL:   if (mem_ack_i) state_d = CS_LOOKUP;
            default:                  state_d = CS_LOOKUP;
        endcase
    end

    always_comb begin
        in_lookup_o     = 1'b0;
        mem_req_valid_o = 1'b0;
        mem_req_write_o = 1'b0;
        fill_done_o     = 1'b0;
        unique case (state_q)
            CS_LOOKUP: in_lookup_o = 1'b1;
            CS_WRBACK: begin
                mem_req_valid_o = 1'b1;
                mem_req_write_o = 1'b1;
            end
            CS_FILL: begin
                mem_req_valid_o = 1'b1;
                fill_done_o     = mem_ack_i;
            end
            default: in_lookup_o = 1'b1;
        endcase
    end

    // R8
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_write_o && mem_ack_i) |=> (mem_req_valid_o && !mem_req_write_o));

    // R11
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_ack_i) |=> (mem_req_valid_o && $stable(mem_req_write_o)));

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned SETS       = 8,
    parameter int unsigned LINE_BYTES = 4,
    localparam int unsigned IDX_W     = $clog2(SETS),
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned LADDR_W   = ADDR_W - OFF_W,
    localparam int unsigned LINE_W    = 8 * LINE_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [7:0]         req_wdata,
    output logic               req_ready,
    output logic [7:0]         rsp_rdata,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [LADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rdata
);

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [OFF_W-1:0] req_off;

    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_off = req_addr[OFF_W-1:0];

    logic              in_lookup, fill_done;
    logic [IDX_W-1:0]  miss_idx_q;
    logic [TAG_W-1:0]  miss_tag_q;
    logic              victim_q;
    logic [IDX_W-1:0]  rd_idx;

    logic [NUM_WAYS-1:0] hit_vec, way_valid, way_dirty, byte_we, fill_we;
    logic [TAG_W-1:0]    way_tag  [NUM_WAYS];
    logic [LINE_W-1:0]   way_line [NUM_WAYS];

    logic lookup_hit, hit_way, lru_way, victim_now, victim_dirty, miss;

    assign rd_idx = in_lookup ? req_idx : miss_idx_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign byte_we[w] = in_lookup && req_valid && req_write && hit_vec[w];
        assign fill_we[w] = fill_done && (victim_q == w[0]);

        cache2w_way #(
            .SETS  (SETS),
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .OFF_W (OFF_W),
            .LINE_W(LINE_W)
        ) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .idx_i      (rd_idx),
            .cmp_tag_i  (req_tag),
            .hit_o      (hit_vec[w]),
            .valid_o    (way_valid[w]),
            .dirty_o    (way_dirty[w]),
            .tag_o      (way_tag[w]),
            .line_o     (way_line[w]),
            .byte_we_i  (byte_we[w]),
            .byte_off_i (req_off),
            .byte_i     (req_wdata),
            .fill_we_i  (fill_we[w]),
            .fill_tag_i (miss_tag_q),
            .fill_line_i(mem_rdata)
        );
    end

    assign lookup_hit = |hit_vec;
    assign hit_way    = hit_vec[1];

    // Empty way first, then the recency bit
    always_comb begin
        if (!way_valid[0])      victim_now = 1'b0;
        else if (!way_valid[1]) victim_now = 1'b1;
        else                    victim_now = lru_way;
        victim_dirty = way_valid[victim_now] && way_dirty[victim_now];
    end

    assign miss = in_lookup && req_valid && !lookup_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_idx_q <= '0;
            miss_tag_q <= '0;
            victim_q   <= 1'b0;
        end else if (miss) begin
            miss_idx_q <= req_idx;
            miss_tag_q <= req_tag;
            victim_q   <= victim_now;
        end
    end

    cache2w_lru #(
        .SETS (SETS),
        .IDX_W(IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_i      (rd_idx),
        .touch_i    ((in_lookup && req_valid && lookup_hit) || fill_done),
        .touch_way_i(fill_done ? victim_q : hit_way),
        .lru_way_o  (lru_way)
    );

    cache2w_ctl u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_i         (miss),
        .victim_dirty_i (victim_dirty),
        .mem_ack_i      (mem_ack),
        .in_lookup_o    (in_lookup),
        .mem_req_valid_o(mem_req_valid),
        .mem_req_write_o(mem_req_write),
        .fill_done_o    (fill_done)
    );

    logic [LINE_W-1:0] sel_line;

    assign sel_line     = hit_way ? way_line[1] : way_line[0];
    assign rsp_rdata    = sel_line[{req_off, 3'b000} +: 8];
    assign req_ready    = in_lookup && lookup_hit;
    assign mem_wdata    = way_line[victim_q];
    assign mem_req_addr = mem_req_write ? {way_tag[victim_q], miss_idx_q}
                                        : {miss_tag_q, miss_idx_q};

    // R2
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_lookup |-> $onehot0(hit_vec));

    // R8
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (way_valid[victim_q] && way_dirty[victim_q]));

    // R10
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R11
    mem_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> $stable(mem_req_addr));

    // R10
    fill_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && req_valid) |=> (!req_valid || !$stable(req_addr) || req_ready));

endmodule

// File: tb/sim_cache2w_top.sv
`timescale 1ns/1ps
module sim_cache2w_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        mem_req_valid, mem_req_write;
    logic [10:0] mem_req_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    cache2w_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] mem_line  [2048];
    logic [31:0] gold_line [2048];

    // reference model state
    logic [7:0] m_tag [8][2];
    logic       m_val [8][2];
    logic       m_dty [8][2];
    logic       m_lru [8];

    int          wb_cnt = 0, fill_cnt = 0, fills_at_wb = 0;
    logic [10:0] last_wb_addr = '0;
    int          lat_cnt = 0;

    function automatic logic [31:0] init_val(input int i);
        return (i * 32'h0100_0193) ^ 32'hA5C3_5A3C;
    endfunction

    // backing memory: ack in the fourth cycle of a transaction
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req_valid) begin
            if (lat_cnt == LAT - 1) begin
                mem_ack <= 1'b1;
                if (mem_req_write) begin
                    mem_line[mem_req_addr] <= mem_wdata;
                    wb_cnt       = wb_cnt + 1;
                    last_wb_addr = mem_req_addr;
                    fills_at_wb  = fill_cnt;
                end else begin
                    mem_rdata <= mem_line[mem_req_addr];
                    fill_cnt  = fill_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R12: memory port idle in reset
        chk(mem_req_valid == 1'b0, "R12", "mem idle in reset", 32'(mem_req_valid), 0);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_val[s][w] = 1'b0;
                m_dty[s][w] = 1'b0;
            end
        end
        for (int i = 0; i < 2048; i++) gold_line[i] = mem_line[i];
    endtask

    task automatic access(input bit wr, input logic [12:0] a, input logic [7:0] wd,
                          input string rq, output bit got_hit, output logic [7:0] rd);
        logic [7:0]  t;
        logic [2:0]  s;
        logic [1:0]  off;
        bit          hit_exp, hw, vic, wb_exp;
        logic [10:0] wb_addr;
        int          wb0, fl0, stalls;
        t = a[12:5]; s = a[4:2]; off = a[1:0];
        hw = m_val[s][1] && m_tag[s][1] == t;
        hit_exp = (m_val[s][0] && m_tag[s][0] == t) || hw;
        if (!m_val[s][0])      vic = 1'b0;
        else if (!m_val[s][1]) vic = 1'b1;
        else                   vic = m_lru[s];
        wb_exp  = !hit_exp && m_val[s][vic] && m_dty[s][vic];
        wb_addr = {m_tag[s][vic], s};
        wb0 = wb_cnt; fl0 = fill_cnt; stalls = 0;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #1;
        got_hit = req_ready;
        while (!req_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = rsp_rdata;
        @(posedge clk);
        #1;
        req_valid = 1'b0;

        // R2 R4 R5 R6: hit/miss as predicted
        chk(got_hit == hit_exp, rq, "hit flag", 32'(got_hit), 32'(hit_exp));
        if (hit_exp) begin
            // R7: no memory traffic on any hit
            chk(wb_cnt == wb0 && fill_cnt == fl0, "R7", "mem transactions on hit",
                32'(wb_cnt - wb0 + fill_cnt - fl0), 0);
        end else begin
            // R10: stall length
            chk(stalls == 1 + (wb_exp ? 2 : 1) * (LAT + 1), "R10", "stall cycles",
                32'(stalls), 32'(1 + (wb_exp ? 2 : 1) * (LAT + 1)));
            // R8: write-back only for dirty victim
            chk(wb_cnt - wb0 == int'(wb_exp), "R8", "write-back count",
                32'(wb_cnt - wb0), 32'(wb_exp));
            // R11: one fill per miss
            chk(fill_cnt - fl0 == 1, "R11", "fill count", 32'(fill_cnt - fl0), 1);
            if (wb_exp) begin
                chk(last_wb_addr == wb_addr, "R8", "write-back address",
                    32'(last_wb_addr), 32'(wb_addr));
                chk(fills_at_wb == fl0, "R8", "write-back before fill",
                    32'(fills_at_wb), 32'(fl0));
            end
        end
        if (!wr) begin
            // R3: byte selection
            chk(rd == gold_line[{t, s}][{off, 3'b000} +: 8], "R3", "read byte",
                32'(rd), 32'(gold_line[{t, s}][{off, 3'b000} +: 8]));
        end

        if (!hit_exp) begin
            m_tag[s][vic] = t;
            m_val[s][vic] = 1'b1;
            m_dty[s][vic] = 1'b0;
            hw = vic;
        end
        m_lru[s] = ~hw;
        if (wr) begin
            m_dty[s][hw] = 1'b1;
            gold_line[{t, s}][{off, 3'b000} +: 8] = wd;
        end
    endtask

    initial begin
        bit         h;
        logic [7:0] d;
        bit         exp_seq [6];
        logic [12:0] seq [6];
        logic [15:0] lfsr;

        for (int i = 0; i < 2048; i++) mem_line[i] = init_val(i);
        do_reset();

        // R13: A B A C A B in set 0 with tags 1, 3, 0
        seq = '{13'h020, 13'h060, 13'h020, 13'h000, 13'h020, 13'h060};
        exp_seq = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        for (int i = 0; i < 6; i++) begin
            access(1'b0, seq[i], 8'h00, "R5/R6", h, d);
            chk(h == exp_seq[i], "R13", "sequence hit", 32'(h), 32'(exp_seq[i]));
        end

        // R1: same line at other offsets hits; changed set or tag misses
        access(1'b0, 13'h1A7, 8'h00, "R1", h, d);
        chk(h == 1'b0, "R1", "first touch misses", 32'(h), 0);
        for (int o = 0; o < 4; o++) begin
            access(1'b0, 13'h1A4 | 13'(o), 8'h00, "R1", h, d);
            chk(h == 1'b1, "R1", "offset shares line", 32'(h), 1);
        end
        access(1'b0, 13'h1A7 ^ 13'h020, 8'h00, "R1", h, d);
        chk(h == 1'b0, "R1", "tag bit 5 separates", 32'(h), 0);
        access(1'b0, 13'h1A7 ^ 13'h004, 8'h00, "R1", h, d);
        chk(h == 1'b0, "R1", "set bit 2 separates", 32'(h), 0);

        // R7: write hit, then read back from cache
        access(1'b1, 13'h1A5, 8'hC3, "R7", h, d);
        chk(h == 1'b1, "R7", "write hit", 32'(h), 1);
        access(1'b0, 13'h1A5, 8'h00, "R7", h, d);
        chk(d == 8'hC3, "R7", "cached write visible", 32'(d), 32'hC3);

        // R9: write miss allocates, later evicted and reloaded
        access(1'b1, 13'h0E5, 8'h5D, "R9", h, d);
        chk(h == 1'b0, "R9", "write miss", 32'(h), 0);
        access(1'b0, 13'h0E5, 8'h00, "R9", h, d);
        chk(h == 1'b1 && d == 8'h5D, "R9", "allocated and written", {23'd0, h, d}, 32'h15D);
        access(1'b0, 13'h1E5, 8'h00, "R9", h, d);
        access(1'b0, 13'h2E5, 8'h00, "R9", h, d);
        access(1'b0, 13'h3E5, 8'h00, "R9", h, d);
        access(1'b0, 13'h0E5, 8'h00, "R9", h, d);
        chk(h == 1'b0 && d == 8'h5D, "R9", "reloaded after write-back", {23'd0, h, d}, 32'h05D);

        // R12/R4: reset invalidates lines whose stale tags still match
        do_reset();
        access(1'b0, 13'h0E5, 8'h00, "R4", h, d);
        chk(h == 1'b0, "R4", "stale tag after reset misses", 32'(h), 0);
        access(1'b0, 13'h020, 8'h00, "R12", h, d);
        chk(h == 1'b0, "R12", "cleared valid after reset", 32'(h), 0);

        // near-exhaustive sweep: every set, offset, four tags, mixed writes
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[7] & lfsr[9], {6'b010000, lfsr[1:0], lfsr[4:2], lfsr[6:5]},
                   lfsr[15:8], "R2/R6", h, d);
        end

        summary();
        $finish;
    end

endmodule